// File: doc/BRIEF.md
# Oscillator Startup Timer Monitor

This block decides when a crystal oscillator may be trusted after software turns it on. Software first writes a startup-delay value into a register-style field. It then raises an enable bit. The block waits for that many fixed reference intervals and then raises a clock-good status flag. Each interval is 64 µs long and is marked by a one-cycle tick from a free-running timebase. The flag comes from the programmed delay alone; the block never counts oscillator edges.

The delay field is sampled once, in the cycle the enable rises. Later writes to the field do not change the measurement that is running. Dropping the enable aborts the measurement and clears the flag. Raising the enable again starts a new measurement from zero, using whatever value the field holds at that moment.

Top module: `osc_start_monitor`

## Requirements
- R1: After reset, `good_o` is low and stays low until a measurement completes.
- R2: The value on `delay_i` is captured in the cycle `enable_i` rises. Changes to `delay_i` while the enable stays high do not change when `good_o` rises.
- R3: The interval count advances only in cycles where `tick_i` is high. Any number of cycles without a tick leaves `good_o` low.
- R4: For a captured value N, `good_o` goes high on the clock edge that follows the cycle holding the (N+1)th counted tick. A counted tick is a tick in a cycle after the enable-rise cycle, with the enable high.
- R5: A captured value of zero raises `good_o` on the first counted tick after the enable rises.
- R6: A cycle with `enable_i` low makes `good_o` low from the next edge on and discards the partial count. A later enable rise starts counting from zero with a newly captured value.
- R7: Once `good_o` is high, it stays high for as long as `enable_i` stays high, whatever `tick_i` and `delay_i` do.
- R8: A tick in the same cycle as the enable rise is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Oscillator enable bit from software |
| delay_i | input | DELAY_W | Programmed startup delay, in 64 µs intervals minus one |
| tick_i | input | 1 | One-cycle pulse once per 64 µs reference interval |
| good_o | output | 1 | Clock-good status flag |

## Verification
The bench covers several edge cases, each with its typical wrong result:
- A zero delay. An off-by-one design would need two ticks instead of one.
- The all-ones delay. A design with a counter one bit too narrow would wrap and never report good.
- A tick that lands exactly on the enable-rise cycle. A careless design would count it and finish one interval early.
- Rewriting the delay field in the middle of a count. A design that did not latch the field would finish at the new value.
- Dropping the enable part way through, then raising it again. A design that kept the partial count would report good too soon.
- Random enable, tick and delay traffic, which checks every cycle against a cycle-level model.

// File: rtl/osm_pkg.sv
package osm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_GOOD  = 2'd2
    } osm_state_e;

    typedef struct packed {
        osm_state_e state;
    } osm_fsm_t;

endpackage

// File: rtl/osm_rise_detect.sv
module osm_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } rd_regs_t;

    rd_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = level_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise_o = level_i & ~r_q.prev;

endmodule

// File: rtl/osm_interval_counter.sv
module osm_interval_counter #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               load_i,
    input  logic [DELAY_W-1:0] delay_i,
    input  logic               advance_i,
    output logic               done_o
);
    typedef struct packed {
        logic [DELAY_W-1:0] target;
        logic [DELAY_W-1:0] count;
    } ic_regs_t;

    ic_regs_t r_d, r_q;
    logic     hit;

    assign hit = (r_q.count == r_q.target);

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.count = '0;
        end else if (load_i) begin
            r_d.target = delay_i;
            r_d.count  = '0;
        end else if (advance_i && !hit) begin
            r_d.count = r_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o = advance_i & hit;

    // The count never passes the captured target, so the counter cannot wrap.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count <= r_q.target);

    // The captured target changes only on a load.
    p_target_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(r_q.target));

endmodule

// File: rtl/osc_start_monitor.sv
module osc_start_monitor
    import osm_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic [DELAY_W-1:0] delay_i,
    input  logic               tick_i,
    output logic               good_o
);
    osm_fsm_t r_d, r_q;
    logic     rise_w;
    logic     done_w;
    logic     advance_w;

    osm_rise_detect i_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (enable_i),
        .rise_o  (rise_w)
    );

    assign advance_w = enable_i & tick_i & (r_q.state == ST_COUNT);

    osm_interval_counter #(.DELAY_W(DELAY_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (~enable_i),
        .load_i    (rise_w),
        .delay_i   (delay_i),
        .advance_i (advance_w),
        .done_o    (done_w)
    );

    always_comb begin
        r_d = r_q;
        if (!enable_i) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE:  if (rise_w) r_d.state = ST_COUNT;
                ST_COUNT: if (done_w) r_d.state = ST_GOOD;
                ST_GOOD:  r_d.state = ST_GOOD;
                default:  r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign good_o = (r_q.state == ST_GOOD);

    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !good_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (good_o && enable_i) |=> good_o);

    p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(good_o) |-> $past(tick_i));

    p_no_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w |=> !good_o);

endmodule

// File: tb/test_osc_start_monitor.sv
`timescale 1ns/1ps
module test_osc_start_monitor;
    localparam int DELAY_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               enable_i = 1'b0;
    logic [DELAY_W-1:0] delay_i = '0;
    logic               tick_i = 1'b0;
    logic               good_o;

    int n_checks = 0;
    int n_errors = 0;

    // Bench model, built from the requirements.
    int          m_state = 0;   // 0 idle, 1 counting, 2 good
    int          m_cnt = 0;
    int          m_tgt = 0;
    logic        m_prev_en = 1'b0;

    always #4 clk = ~clk;

    osc_start_monitor #(.DELAY_W(DELAY_W)) i_osc_start_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .delay_i  (delay_i),
        .tick_i   (tick_i),
        .good_o   (good_o)
    );

    function automatic logic exp_good();
        return m_state == 2;
    endfunction

    task automatic model_step();
        if (!enable_i) begin
            m_state = 0;
            m_cnt   = 0;
        end else if (enable_i && !m_prev_en) begin
            m_state = 1;            // R2 capture, R8 tick ignored
            m_tgt   = int'(delay_i);
            m_cnt   = 0;
        end else if (m_state == 1 && tick_i) begin
            if (m_cnt == m_tgt) m_state = 2;   // R4 / R5
            else m_cnt++;
        end
        m_prev_en = enable_i;
    endtask

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: good_o=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs for one cycle, advance, then compare.
    task automatic cyc(string req, logic en, logic [DELAY_W-1:0] d, logic tk);
        enable_i = en;
        delay_i  = d;
        tick_i   = tk;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(req, good_o, exp_good());
    endtask

    // Count ticks from enable rise until good; return ticks used.
    task automatic run_to_good(string req, logic [DELAY_W-1:0] d, int exp_ticks);
        int ticks = 0;
        cyc(req, 1'b1, d, 1'b0);
        while (!good_o && ticks < 400) begin
            cyc(req, 1'b1, d, 1'b1);
            ticks++;
        end
        n_checks++;
        if (ticks != exp_ticks) begin
            n_errors++;
            $display("FAIL %s: ticks=%0d expected=%0d", req, ticks, exp_ticks);
        end
        cyc(req, 1'b0, d, 1'b0);
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog: ran=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", good_o, 1'b0);
        for (int i = 0; i < 5; i++) cyc("R1", 1'b0, 8'h00, 1'b1);

        // R5: zero delay, good on first tick
        run_to_good("R5", 8'd0, 1);
        // R4: several delays
        run_to_good("R4", 8'd3, 4);
        run_to_good("R4", 8'd17, 18);
        // R4: all-ones delay
        run_to_good("R4", 8'hFF, 256);

        // R3: long stretch without ticks keeps good low
        cyc("R3", 1'b1, 8'd0, 1'b0);
        for (int i = 0; i < 60; i++) cyc("R3", 1'b1, 8'd0, 1'b0);
        cyc("R3", 1'b1, 8'd0, 1'b1);
        check("R3", good_o, 1'b1);
        cyc("R6", 1'b0, 8'd0, 1'b0);

        // R8: tick on the rise cycle is not counted
        cyc("R8", 1'b1, 8'd0, 1'b1);
        check("R8", good_o, 1'b0);
        cyc("R8", 1'b1, 8'd0, 1'b1);
        check("R8", good_o, 1'b1);
        // R7: stays high under ticks and delay changes
        for (int i = 0; i < 20; i++) cyc("R7", 1'b1, 8'(i), 1'(i % 2));
        check("R7", good_o, 1'b1);
        cyc("R6", 1'b0, 8'd0, 1'b0);
        check("R6", good_o, 1'b0);

        // R2: rewrite delay mid-count
        cyc("R2", 1'b1, 8'd5, 1'b0);
        cyc("R2", 1'b1, 8'd200, 1'b1);
        for (int i = 0; i < 4; i++) cyc("R2", 1'b1, 8'd0, 1'b1);
        check("R2", good_o, 1'b0);
        cyc("R2", 1'b1, 8'd0, 1'b1);
        check("R2", good_o, 1'b1);
        cyc("R6", 1'b0, 8'd0, 1'b0);

        // R6: abort mid-count, restart from zero
        cyc("R6", 1'b1, 8'd4, 1'b0);
        for (int i = 0; i < 3; i++) cyc("R6", 1'b1, 8'd4, 1'b1);
        cyc("R6", 1'b0, 8'd4, 1'b1);
        run_to_good("R6", 8'd4, 5);

        // Random traffic checked cycle by cycle against the model
        for (int i = 0; i < 20000; i++) begin
            logic en;
            en = ($urandom % 64 == 0) ? ~enable_i : enable_i;
            cyc("R4", en, 8'($urandom % 12), 1'($urandom % 4 == 0));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule